// File: doc/BRIEF.md
# Home VLAN Forwarding Mask Generator

This block supplies the set of egress ports that a frame arriving on a given ingress port may be forwarded to. It is used in a 16-port switch that can isolate its ports in a fixed "home" arrangement. In that arrangement each ordinary port forms a private group of its own. A small number of shared uplink ports, one or two, can reach every port and can be reached from every port. A typical use is several rooms sharing one router or server while being kept apart from each other.

The configuration comes from strap inputs and is captured while reset is held. These straps are the isolation enable, the topology selector and four link-aggregation group enables. Isolation stays inactive whenever any aggregation group is enabled. After reset the captured configuration does not change. The egress mask is a purely combinational function of the ingress port index and that captured configuration.

Top module: `hvlan_fwd_mask`

## Requirements
- R1: When isolation is inactive (the default after reset with all straps low), the mask for ingress port p has every bit set except bit p.
- R2: If any of the four aggregation strap bits is 1 at capture, isolation is inactive even when the isolation enable strap is 1, and the masks follow R1.
- R3: With isolation active and topology strap = 1, port 15 is the single shared port, and ingress ports 0 to 14 each get the mask 16'h8000.
- R4: With isolation active and topology strap = 1, ingress port 15 gets the mask 16'h7FFF.
- R5: With isolation active and topology strap = 0 (the default), ports 14 and 15 are shared, and ingress ports 0 to 13 each get the mask 16'hC000.
- R6: With isolation active and topology strap = 0, ingress port 14 gets 16'hBFFF and ingress port 15 gets 16'h7FFF.
- R7: The bit of the ingress port itself is never set in its mask.
- R8: The straps are captured on every rising clock edge while rst is 1. Strap changes while rst is 0 have no effect on any mask.
- R9: The mask follows a change of ingress_port within the same cycle, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; straps are captured while high |
| strap_iso_en | input | 1 | Isolation enable strap |
| strap_topo | input | 1 | Topology strap: 1 = one shared port, 0 = two shared ports |
| strap_agg_en | input | 4 | Link-aggregation group enable straps |
| ingress_port | input | 4 | Ingress port index |
| egress_mask | output | 16 | Allowed egress ports, bit n = port n |

## Verification
The captured configuration takes effect on the clock edge on which rst is sampled high. The mask is due zero cycles after an ingress_port change. The bench therefore drives each index on the falling edge and compares the output one nanosecond later, before the next rising edge. For the capture rule, the bench deasserts reset and then toggles every strap. It waits several rising edges and rechecks the masks, which must be unchanged.

// File: rtl/hvlan_pkg.sv
package hvlan_pkg;

    localparam int AGG_GROUPS = 4;

    typedef enum logic {
        TOPO_TWO_SHARED = 1'b0,
        TOPO_ONE_SHARED = 1'b1
    } topo_e;

    typedef struct packed {
        logic                  iso_en;
        topo_e                 topo;
        logic [AGG_GROUPS-1:0] agg_en;
    } strap_cfg_t;

    // Number of shared uplink ports implied by a topology
    function automatic int unsigned shared_count(topo_e t);
        return (t == TOPO_ONE_SHARED) ? 1 : 2;
    endfunction

    // Isolation is active only with no aggregation group enabled
    function automatic logic iso_active(strap_cfg_t c);
        return c.iso_en && (c.agg_en == '0);
    endfunction

endpackage

// File: rtl/hvlan_strap_latch.sv
module hvlan_strap_latch
    import hvlan_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  strap_cfg_t cfg_d,
    output strap_cfg_t cfg_q
);

    // Sample straps throughout reset, hold afterwards
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= cfg_d;
        end
    end

endmodule

// File: rtl/hvlan_mask_core.sv
module hvlan_mask_core
    import hvlan_pkg::*;
#(
    parameter int NUM_PORTS = 16,
    parameter int PORT_W    = $clog2(NUM_PORTS)
) (
    input  strap_cfg_t            cfg,
    input  logic [PORT_W-1:0]     port_idx,
    output logic [NUM_PORTS-1:0]  mask
);

    localparam int LAST = NUM_PORTS - 1;

    logic        active;
    int unsigned first_shared;
    logic        src_shared;

    always_comb begin
        active       = iso_active(cfg);
        first_shared = NUM_PORTS - shared_count(cfg.topo);
        src_shared   = (int'(port_idx) >= int'(first_shared));
    end

    for (genvar e = 0; e < NUM_PORTS; e++) begin : g_egress
        logic dst_shared;
        logic is_self;
        always_comb begin
            dst_shared = (e >= int'(first_shared));
            is_self    = (port_idx == PORT_W'(e));
            mask[e]    = !is_self && (!active || src_shared || dst_shared);
        end
    end

    logic unused_last;
    assign unused_last = (LAST > 0);

endmodule

// File: rtl/hvlan_fwd_mask.sv
module hvlan_fwd_mask
    import hvlan_pkg::*;
#(
    parameter int NUM_PORTS = 16,
    parameter int PORT_W    = $clog2(NUM_PORTS)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  strap_iso_en,
    input  logic                  strap_topo,
    input  logic [AGG_GROUPS-1:0] strap_agg_en,
    input  logic [PORT_W-1:0]     ingress_port,
    output logic [NUM_PORTS-1:0]  egress_mask
);

    strap_cfg_t cfg_raw;
    strap_cfg_t cfg_held;

    always_comb begin
        cfg_raw.iso_en = strap_iso_en;
        cfg_raw.topo   = topo_e'(strap_topo);
        cfg_raw.agg_en = strap_agg_en;
    end

    hvlan_strap_latch u_latch (
        .clk   (clk),
        .rst   (rst),
        .cfg_d (cfg_raw),
        .cfg_q (cfg_held)
    );

    hvlan_mask_core #(
        .NUM_PORTS (NUM_PORTS),
        .PORT_W    (PORT_W)
    ) u_core (
        .cfg      (cfg_held),
        .port_idx (ingress_port),
        .mask     (egress_mask)
    );

endmodule

// File: rtl/hvlan_fwd_mask_chk.sv
module hvlan_fwd_mask_chk #(
    parameter int NUM_PORTS = 16,
    parameter int PORT_W    = $clog2(NUM_PORTS)
) (
    input logic                 clk,
    input logic                 rst,
    input logic [PORT_W-1:0]    ingress_port,
    input logic [NUM_PORTS-1:0] egress_mask
);

    // R7
    self_bit_clear_chk: assert property (@(posedge clk) disable iff (rst)
        egress_mask[ingress_port] == 1'b0);

    // R3
    top_port_reachable_chk: assert property (@(posedge clk) disable iff (rst)
        (ingress_port != PORT_W'(NUM_PORTS-1)) |-> egress_mask[NUM_PORTS-1]);

    // R4
    top_port_full_fanout_chk: assert property (@(posedge clk) disable iff (rst)
        (ingress_port == PORT_W'(NUM_PORTS-1)) |-> ($countones(egress_mask) == NUM_PORTS-1));

    // R8
    cfg_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $stable(ingress_port)) |-> $stable(egress_mask));

endmodule

bind hvlan_fwd_mask hvlan_fwd_mask_chk #(
    .NUM_PORTS (NUM_PORTS),
    .PORT_W    (PORT_W)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .ingress_port (ingress_port),
    .egress_mask  (egress_mask)
);

// File: tb/sim_hvlan_fwd_mask.sv
module sim_hvlan_fwd_mask;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        strap_iso_en = 1'b0;
    logic        strap_topo = 1'b0;
    logic [3:0]  strap_agg_en = 4'h0;
    logic [3:0]  ingress_port = 4'h0;
    logic [15:0] egress_mask;

    int n_checks = 0;
    int n_fails  = 0;

    always #10 clk = ~clk;

    hvlan_fwd_mask u0 (
        .clk          (clk),
        .rst          (rst),
        .strap_iso_en (strap_iso_en),
        .strap_topo   (strap_topo),
        .strap_agg_en (strap_agg_en),
        .ingress_port (ingress_port),
        .egress_mask  (egress_mask)
    );

    function automatic logic [15:0] ref_mask(int p, bit iso, bit topo, logic [3:0] agg);
        logic [15:0] m;
        if (!iso || agg != 4'h0) m = 16'hFFFF;
        else if (topo) m = (p == 15) ? 16'hFFFF : 16'h8000;
        else m = (p >= 14) ? 16'hFFFF : 16'hC000;
        m[p] = 1'b0;
        return m;
    endfunction

    task automatic check_port(int p, logic [15:0] exp, string tag);
        @(negedge clk);
        ingress_port = 4'(p);
        #1;
        n_checks++;
        if (egress_mask !== exp) begin
            n_fails++;
            $display("FAIL %s port %0d: got %h expected %h", tag, p, egress_mask, exp);
        end
    endtask

    task automatic apply_reset(bit iso, bit topo, logic [3:0] agg);
        @(negedge clk);
        rst = 1'b1;
        strap_iso_en = iso;
        strap_topo = topo;
        strap_agg_en = agg;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic sweep(bit iso, bit topo, logic [3:0] agg, string tag);
        for (int p = 0; p < 16; p++) check_port(p, ref_mask(p, iso, topo, agg), tag);
    endtask

    task automatic t_default;
        apply_reset(0, 0, 4'h0);
        check_port(0, 16'hFFFE, "R1 reset state");
        sweep(0, 0, 4'h0, "R1 R7");
    endtask

    task automatic t_single_shared;
        apply_reset(1, 1, 4'h0);
        check_port(3, 16'h8000, "R3");
        check_port(14, 16'h8000, "R3");
        check_port(15, 16'h7FFF, "R4");
        sweep(1, 1, 4'h0, "R3 R4 R7");
    endtask

    task automatic t_two_shared;
        apply_reset(1, 0, 4'h0);
        check_port(0, 16'hC000, "R5");
        check_port(13, 16'hC000, "R5");
        check_port(14, 16'hBFFF, "R6");
        check_port(15, 16'h7FFF, "R6");
        sweep(1, 0, 4'h0, "R5 R6 R7");
    endtask

    task automatic t_agg_override;
        logic [3:0] pats [4] = '{4'h1, 4'h2, 4'h4, 4'h8};
        for (int i = 0; i < 4; i++) begin
            apply_reset(1, i[0], pats[i]);
            check_port(2, 16'hFFFB, "R2");
            check_port(15, 16'h7FFF, "R2");
        end
    endtask

    task automatic t_straps_after_reset;
        apply_reset(1, 1, 4'h0);
        @(negedge clk);
        strap_iso_en = 1'b0;
        strap_topo = 1'b0;
        strap_agg_en = 4'hF;
        repeat (4) @(negedge clk);
        check_port(5, 16'h8000, "R8");
        check_port(14, 16'h8000, "R8");
        check_port(15, 16'h7FFF, "R8");
    endtask

    task automatic t_same_cycle;
        apply_reset(1, 0, 4'h0);
        @(negedge clk);
        ingress_port = 4'd7;
        #1;
        n_checks++;
        if (egress_mask !== 16'hC000) begin
            n_fails++;
            $display("FAIL R9 first index: got %h expected %h", egress_mask, 16'hC000);
        end
        ingress_port = 4'd14;
        #1;
        n_checks++;
        if (egress_mask !== 16'hBFFF) begin
            n_fails++;
            $display("FAIL R9 same cycle: got %h expected %h", egress_mask, 16'hBFFF);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_default();
        t_single_shared();
        t_two_shared();
        t_agg_override();
        t_straps_after_reset();
        t_same_cycle();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        #1000000;
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule